// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Square-Wave Unit

This block turns the timing events of a real-time clock into three latched interrupt sources and a square-wave pin. A reference prescaler converts edges of the reference oscillator into half-period ticks of a 32.768 kHz time base. A binary stage counter then produces a square wave and a periodic event, both at a rate picked by a 4-bit logarithmic code. An alarm comparator checks the current seconds, minutes and hours against three alarm bytes each time the external time counter reports that an update has finished. The update-finished strobe also raises its own flag.

The three flags are gathered into a flag byte that software reads. Reading it clears it. Bit 7 of that byte, and the interrupt request pin, show whether any flag is set while its enable is on. The time counter and the bus access logic sit outside this block. All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `flags_c` reads 0x00 and `irq` and `sqw` are low.
- R2: On a cycle with `upd_done` high, the alarm flag is set when every field matches. A field matches if its alarm byte equals the time byte, or if the alarm byte has bits 7 and 6 both set, in which case that field matches any time value.
- R3: If any field neither equals its time byte nor has both top bits set, the alarm flag is not set. An alarm byte with only bit 7 set is compared exactly.
- R4: A cycle with `upd_done` high sets the update flag on the next clock edge.
- R5: In 32.768 kHz mode with rate code n from 1 to 15, the internal wave toggles on every 2^(n-1)-th reference edge counted from the end of a divider hold. The periodic flag is set each time the wave rises. Code 0 produces no toggles and no periodic flags.
- R6: `div_mode` 010 passes every reference edge through as a half-tick. Mode 001 passes one in every 32 edges, and mode 000 one in every 128. Every other code holds the divider: the stage counter is cleared, the wave is parked low, and no toggles or periodic flags occur.
- R7: `sqw` follows the internal wave while `sqw_en` is high and is low otherwise.
- R8: `flags_c` bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3:0 are zero. Flags are set whatever their enables are.
- R9: `flags_c` bit 7 and `irq` are high exactly when some flag is set together with its enable: `pie_en` for periodic, `aie_en` for alarm, `uie_en` for update.
- R10: A cycle with `flag_rd` high returns the current `flags_c` and clears all flags on that clock edge. `irq` is low in the following cycle unless a new event arrived.
- R11: An event that arrives in the same cycle as a read leaves its flag set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge (both edges) |
| div_mode | input | 3 | Divider mode: 000, 001, 010 run; others hold |
| rate_sel | input | 4 | Logarithmic periodic / square-wave rate code |
| pie_en | input | 1 | Periodic interrupt enable |
| aie_en | input | 1 | Alarm interrupt enable |
| uie_en | input | 1 | Update-finished interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| upd_done | input | 1 | Strobe from the time counter after each update |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| flag_rd | input | 1 | Read strobe of the flag byte; clears it |
| flags_c | output | 8 | Flag byte {any, periodic, alarm, update, 0000} |
| irq | output | 1 | Interrupt request, high while bit 7 is set |
| sqw | output | 1 | Square-wave output |

## Verification
The critical overlap is a flag event that lands in the same cycle as a read of the flag byte, because the clear and the set meet at one register. The bench first latches the alarm and update flags. It then raises `upd_done` (with a non-matching alarm) and `flag_rd` together. The read must return the old byte, 0x30. On the next cycle only the update flag may remain (0x10). A second run overlaps an update strobe with a read of an empty byte, and the update flag must survive.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int FLD_W = 8;
  localparam int N_FLD = 3;

  typedef enum logic [2:0] {
    DIV_HI_REF  = 3'b000,
    DIV_MID_REF = 3'b001,
    DIV_LO_REF  = 3'b010
  } div_mode_e;

  localparam int BIT_ANY = 7;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } src_t;

endpackage

// File: rtl/rtc_ref_prescaler.sv
module rtc_ref_prescaler
  import rtc_irq_pkg::*;
#(
  parameter int DIV_HI  = 128,
  parameter int DIV_MID = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic [2:0] mode,
  output logic       hold,
  output logic       htick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          run;

  always_comb begin
    run    = 1'b1;
    lim_m1 = '0;
    case (div_mode_e'(mode))
      DIV_HI_REF:  lim_m1 = CW'(DIV_HI - 1);
      DIV_MID_REF: lim_m1 = CW'(DIV_MID - 1);
      DIV_LO_REF:  lim_m1 = '0;
      default:     run    = 1'b0;
    endcase
  end

  assign hold  = !run;
  // >= keeps a count left over from a slower mode from stalling
  assign htick = run && ref_edge && (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (ref_edge) cnt <= htick ? '0 : cnt + 1'b1;
  end

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
  parameter int RATE_W  = 4,
  parameter int STAGE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              htick,
  input  logic [RATE_W-1:0] rate,
  output logic              wave,
  output logic              pulse
);
  logic [STAGE_W-1:0] stage;
  logic [STAGE_W-1:0] mask;
  logic [STAGE_W:0]   span;
  logic               toggle;

  always_comb begin
    span   = (STAGE_W + 1)'(1) << (rate - RATE_W'(1));
    mask   = STAGE_W'(span - 1'b1);
    toggle = htick && (rate != '0) && ((stage & mask) == mask);
    pulse  = toggle && !wave;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      stage <= '0;
      wave  <= 1'b0;
    end else begin
      if (htick)  stage <= stage + 1'b1;
      if (toggle) wave  <= ~wave;
    end
  end

  p_hold_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!wave && stage == '0));
  p_pulse_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> wave);
  p_idle_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0 && !hold) |=> $stable(wave));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF = 3,
  parameter int W  = 8
) (
  input  logic [NF-1:0][W-1:0] now,
  input  logic [NF-1:0][W-1:0] alm,
  output logic                 hit
);
  logic [NF-1:0] fm;

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    assign fm[gi] = (alm[gi][W-1 -: 2] == 2'b11) || (alm[gi] == now[gi]);
  end

  assign hit = &fm;

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t ev,
  input  src_t en,
  input  logic rd,
  output src_t flg,
  output logic any
);
  assign any = |(flg & en);

  always_ff @(posedge clk) begin
    if (!rst_n)  flg <= '0;
    else if (rd) flg <= ev;
    else         flg <= flg | ev;
  end

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ev == '0) |=> (flg == '0 && !any));
  p_event_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flg & $past(ev)) == $past(ev)));
  p_uf_from_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg.uf) |-> $past(ev.uf));

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W  = 4,
  parameter int STAGE_W = 15,
  parameter int DIV_HI  = 128,
  parameter int DIV_MID = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_edge,
  input  logic [2:0]        div_mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              aie_en,
  input  logic              uie_en,
  input  logic              sqw_en,
  input  logic              upd_done,
  input  logic [FLD_W-1:0]  cur_sec,
  input  logic [FLD_W-1:0]  cur_min,
  input  logic [FLD_W-1:0]  cur_hr,
  input  logic [FLD_W-1:0]  alm_sec,
  input  logic [FLD_W-1:0]  alm_min,
  input  logic [FLD_W-1:0]  alm_hr,
  input  logic              flag_rd,
  output logic [7:0]        flags_c,
  output logic              irq,
  output logic              sqw
);
  logic hold, htick, wave, pulse, hit, any;
  logic [N_FLD-1:0][FLD_W-1:0] now_f, alm_f;
  src_t ev, en, flg;

  assign now_f = {cur_hr, cur_min, cur_sec};
  assign alm_f = {alm_hr, alm_min, alm_sec};

  rtc_ref_prescaler #(.DIV_HI(DIV_HI), .DIV_MID(DIV_MID)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .mode(div_mode),
    .hold(hold), .htick(htick));

  rtc_rate_gen #(.RATE_W(RATE_W), .STAGE_W(STAGE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .hold(hold), .htick(htick), .rate(rate_sel),
    .wave(wave), .pulse(pulse));

  rtc_alarm_match #(.NF(N_FLD), .W(FLD_W)) u_alm (
    .now(now_f), .alm(alm_f), .hit(hit));

  always_comb begin
    ev.pf = pulse;
    ev.af = upd_done && hit;
    ev.uf = upd_done;
    en.pf = pie_en;
    en.af = aie_en;
    en.uf = uie_en;
  end

  rtc_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .en(en), .rd(flag_rd),
    .flg(flg), .any(any));

  assign flags_c = {any, flg.pf, flg.af, flg.uf, 4'b0000};
  assign irq     = any;
  assign sqw     = wave && sqw_en;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (flags_c == 8'h00 && !sqw));
  p_alarm_on_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg.af) |-> $past(upd_done));

endmodule

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_edge = 1'b0;
  logic [2:0] div_mode = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0, aie_en = 1'b0, uie_en = 1'b0, sqw_en = 1'b0;
  logic       upd_done = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
  logic [7:0] alm_sec = 8'h01, alm_min = 8'h01, alm_hr = 8'h01;
  logic       flag_rd = 1'b0;
  logic [7:0] flags_c;
  logic       irq, sqw;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .div_mode(div_mode),
    .rate_sel(rate_sel), .pie_en(pie_en), .aie_en(aie_en), .uie_en(uie_en),
    .sqw_en(sqw_en), .upd_done(upd_done), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hr(cur_hr), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .flag_rd(flag_rd), .flags_c(flags_c), .irq(irq), .sqw(sqw));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic read_c(output logic [7:0] v);
    v = flags_c;
    flag_rd = 1'b1;
    tick();
    flag_rd = 1'b0;
  endtask

  task automatic edges(input int n);
    ref_edge = 1'b1;
    repeat (n) tick();
    ref_edge = 1'b0;
  endtask

  task automatic park();
    div_mode = 3'b110;
    tick();
    tick();
  endtask

  task automatic update();
    upd_done = 1'b1;
    tick();
    upd_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 flags", flags_c, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sqw", sqw, 1'b0);
  endtask

  task automatic t_update_and_enables();
    logic [7:0] v;
    read_c(v);
    update();
    chk("R4 update flag", flags_c, 8'h10);
    chk("R8 no enable irq", irq, 1'b0);
    uie_en = 1'b1;
    #1;
    chk("R9 any bit", flags_c, 8'h90);
    chk("R9 irq", irq, 1'b1);
    uie_en = 1'b0;
    pie_en = 1'b1;
    #1;
    chk("R9 other enable", {flags_c, 7'b0, irq}, {8'h10, 8'h00});
    pie_en = 1'b0;
    uie_en = 1'b1;
    #1;
    read_c(v);
    chk("R10 read value", v, 8'h90);
    chk("R10 cleared", flags_c, 8'h00);
    chk("R10 irq low", irq, 1'b0);
    uie_en = 1'b0;
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    aie_en = 1'b1;
    cur_hr = 8'h12; cur_min = 8'h34; cur_sec = 8'h56;
    alm_hr = 8'h12; alm_min = 8'h34; alm_sec = 8'h56;
    read_c(v);
    update();
    chk("R2 exact match", flags_c, 8'hB0);
    chk("R2 irq", irq, 1'b1);
    read_c(v);
    alm_sec = 8'hC0; alm_min = 8'hFF; alm_hr = 8'hC5;
    cur_sec = 8'h07; cur_min = 8'h59; cur_hr = 8'h03;
    update();
    chk("R2 wildcard match", flags_c, 8'hB0);
    read_c(v);
    alm_sec = 8'h57; alm_min = 8'hC0; alm_hr = 8'hC0;
    cur_sec = 8'h56;
    update();
    chk("R3 one field off", flags_c, 8'h10);
    read_c(v);
    alm_sec = 8'h80; cur_sec = 8'h00;
    update();
    chk("R3 single top bit exact", flags_c, 8'h10);
    read_c(v);
    aie_en = 1'b0;
  endtask

  task automatic t_periodic(input int n);
    logic [7:0] v;
    int p;
    logic ew, epf;
    p = 1 << (n - 1);
    ew = 1'b0;
    epf = 1'b0;
    park();
    div_mode = 3'b010;
    rate_sel = 4'(n);
    sqw_en = 1'b1;
    read_c(v);
    for (int k = 1; k <= 4 * p; k++) begin
      ref_edge = 1'b1;
      tick();
      ref_edge = 1'b0;
      tick();
      if (k % p == 0) begin
        ew = ~ew;
        if (ew) epf = 1'b1;
      end
      chk("R5 wave", sqw, ew);
      chk("R5 periodic flag", flags_c[6], epf);
    end
    read_c(v);
  endtask

  task automatic t_rate_zero();
    logic [7:0] v;
    park();
    div_mode = 3'b010;
    rate_sel = 4'd0;
    sqw_en = 1'b1;
    read_c(v);
    edges(20);
    chk("R5 code zero wave", sqw, 1'b0);
    chk("R5 code zero flag", flags_c[6], 1'b0);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    park();
    rate_sel = 4'd1;
    sqw_en = 1'b1;
    read_c(v);
    edges(10);
    chk("R6 hold 110 wave", sqw, 1'b0);
    chk("R6 hold 110 flag", flags_c[6], 1'b0);
    div_mode = 3'b111;
    edges(10);
    chk("R6 hold 111 wave", sqw, 1'b0);
    chk("R6 hold 111 flag", flags_c[6], 1'b0);
  endtask

  task automatic t_prescale(input logic [2:0] m, input int div);
    park();
    div_mode = m;
    rate_sel = 4'd1;
    sqw_en = 1'b1;
    edges(div - 1);
    chk("R6 prescale before", sqw, 1'b0);
    edges(1);
    chk("R6 prescale at", sqw, 1'b1);
  endtask

  task automatic t_sqw_gate();
    park();
    div_mode = 3'b010;
    rate_sel = 4'd1;
    sqw_en = 1'b0;
    edges(1);
    chk("R7 gated low", sqw, 1'b0);
    sqw_en = 1'b1;
    #1;
    chk("R7 follows wave", sqw, 1'b1);
  endtask

  task automatic t_race();
    logic [7:0] v;
    park();
    read_c(v);
    cur_hr = 8'h01; cur_min = 8'h02; cur_sec = 8'h03;
    alm_hr = 8'hC0; alm_min = 8'hC0; alm_sec = 8'hC0;
    update();
    chk("R8 flags without enables", flags_c, 8'h30);
    alm_sec = 8'h04;
    upd_done = 1'b1;
    read_c(v);
    upd_done = 1'b0;
    chk("R11 read returns old", v, 8'h30);
    chk("R11 new event kept", flags_c, 8'h10);
    read_c(v);
    upd_done = 1'b1;
    read_c(v);
    upd_done = 1'b0;
    chk("R11 empty read plus event", flags_c, 8'h10);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_update_and_enables();
    t_alarm();
    t_periodic(1);
    t_periodic(3);
    t_rate_zero();
    t_hold();
    t_prescale(3'b001, 32);
    t_prescale(3'b000, 128);
    t_sqw_gate();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule